// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the 32-bit program counter of a simple in-order core and works out, every cycle, where fetch goes next. The instruction currently at the PC is presented on `instr`, and the datapath supplies a single flag saying whether the two source registers named by the instruction hold equal values. From these inputs the unit finds the next PC with combinational logic. On the next rising clock edge it loads that value, unless the enable is low.

The unit recognises four control opcodes in instruction bits 31..26:
- 2, plain jump.
- 3, jump-and-link.
- 4, branch-if-equal.
- 5, branch-if-not-equal.

Every other opcode is treated as ordinary sequential flow. A branch target is a signed count of instructions, scaled by four and added to PC+4. A jump target is a 26-bit word index. It is placed under the top four bits of PC+4, so a jump cannot leave the 256 MB region that PC+4 lies in. For jump-and-link the unit also presents PC+4 as the return address, together with a strobe.

The control pins are plain, with no handshake. The enable is the only form of back-pressure. While it is low the PC holds, the link strobe stays low, and the inputs must keep describing the same instruction. Reset is synchronous and takes priority over the enable.

Top module: `npc_unit`

## Requirements
- R1: A clock edge with `rst` high loads `pc` with 0, whatever the value of `en`.
- R2: A clock edge with `rst` low and `en` low leaves `pc` unchanged.
- R3: For any opcode other than 2, 3, 4 or 5, `next_pc` equals `pc`+4, whatever the value of `regs_equal`.
- R4: For opcode 4 (bits 31..26) with `regs_equal` high, `next_pc` equals `pc`+4 plus the sign-extended bits 15..0 shifted left by two.
- R5: For opcode 5 with `regs_equal` low, `next_pc` is formed the same way as in R4.
- R6: For opcode 4 with `regs_equal` low, or opcode 5 with `regs_equal` high, `next_pc` equals `pc`+4.
- R7: For opcodes 2 and 3, `next_pc` is `pc`+4 bits 31..28, followed by instruction bits 25..0, followed by two zero bits.
- R8: `link_valid` is high exactly when the opcode is 3, `en` is high and `rst` is low. `link_addr` always equals `pc`+4.
- R9: All address arithmetic wraps modulo 2^32 without any exception.
- R10: A clock edge with `rst` low and `en` high loads `pc` with the `next_pc` value that was present before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low holds the PC |
| instr | input | 32 | Instruction word at the current PC |
| regs_equal | input | 1 | High when the two compared registers are equal |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Value the PC takes at the next enabled edge |
| link_addr | output | 32 | Return address (PC+4) |
| link_valid | output | 1 | Jump-and-link is being committed this cycle |

## Verification
The hardest states to reach are those where the region bits of PC+4 differ from those of the PC, and those where the arithmetic wraps. The PC can only be steered through the unit's own jumps and branches. To reach the region boundary, the stimulus first jumps to the last word below 0x10000000 and then issues a jump-and-link with target 0, which must land in the next region. Wrapping is reached in two ways: a taken branch with the most negative offset from a low address, and a backward branch from PC 0 followed by a sequential step from 0xFFFFFFFC back to 0. The hold and reset-priority cases are driven directly with a control instruction present, so that any leak of the computed target into `pc` would be visible.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned IMM_W    = 16;
  localparam int unsigned TGT_W    = 26;
  localparam int unsigned ALIGN_W  = 2;
  localparam int unsigned OPC_LSB  = XLEN - OPC_W;
  localparam int unsigned REGION_W = XLEN - TGT_W - ALIGN_W;
  localparam int unsigned SEXT_W   = XLEN - IMM_W - ALIGN_W;

  localparam logic [OPC_W-1:0] OPC_JMP  = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JLNK = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;

  typedef enum logic [1:0] {
    FLOW_SEQ    = 2'd0,
    FLOW_BRANCH = 2'd1,
    FLOW_JUMP   = 2'd2
  } flow_e;

  typedef struct packed {
    flow_e            flow;
    logic             on_ne;
    logic             link;
    logic [IMM_W-1:0] imm;
    logic [TGT_W-1:0] tgt;
  } ctl_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctl_t            ctl
);
  logic [OPC_W-1:0] opc;

  assign opc = instr[XLEN-1:OPC_LSB];

  always_comb begin
    ctl.flow  = FLOW_SEQ;
    ctl.on_ne = 1'b0;
    ctl.link  = 1'b0;
    ctl.imm   = instr[IMM_W-1:0];
    ctl.tgt   = instr[TGT_W-1:0];
    case (opc)
      OPC_BEQ:  ctl.flow = FLOW_BRANCH;
      OPC_BNE: begin
        ctl.flow  = FLOW_BRANCH;
        ctl.on_ne = 1'b1;
      end
      OPC_JMP:  ctl.flow = FLOW_JUMP;
      OPC_JLNK: begin
        ctl.flow = FLOW_JUMP;
        ctl.link = 1'b1;
      end
      default:  ctl.flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  ctl_t            ctl,
  input  logic            regs_equal,
  output logic [XLEN-1:0] pc_plus4,
  output logic [XLEN-1:0] next_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN_W;

  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] br_dst;
  logic [XLEN-1:0] jmp_dst;
  logic            br_take;

  assign pc_plus4 = pc + STEP;
  assign br_off   = {{SEXT_W{ctl.imm[IMM_W-1]}}, ctl.imm, {ALIGN_W{1'b0}}};
  assign br_dst   = pc_plus4 + br_off;
  assign jmp_dst  = {pc_plus4[XLEN-1 -: REGION_W], ctl.tgt, {ALIGN_W{1'b0}}};
  assign br_take  = regs_equal ^ ctl.on_ne;

  always_comb begin
    unique case (ctl.flow)
      FLOW_BRANCH: next_pc = br_take ? br_dst : pc_plus4;
      FLOW_JUMP:   next_pc = jmp_dst;
      default:     next_pc = pc_plus4;
    endcase
  end
endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [XLEN-1:0] instr,
  input  logic            regs_equal,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] link_addr,
  output logic            link_valid
);
  ctl_t            ctl;
  logic [XLEN-1:0] pc4;

  npc_decode u_dec (
    .instr (instr),
    .ctl   (ctl)
  );

  npc_target u_tgt (
    .pc         (pc),
    .ctl        (ctl),
    .regs_equal (regs_equal),
    .pc_plus4   (pc4),
    .next_pc    (next_pc)
  );

  npc_pcreg #(.W(XLEN)) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (next_pc),
    .q   (pc)
  );

  assign link_addr  = pc4;
  assign link_valid = ctl.link & en & ~rst;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic [31:0] instr,
  input logic        regs_equal,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic [31:0] link_addr,
  input logic        link_valid
);
  logic [31:0] ref4;
  logic [5:0]  op;
  logic        rst_q = 1'b0;

  assign ref4 = pc + 32'd4;
  assign op   = instr[31:26];

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) AST_RESET_ZERO: assert (pc == 32'd0); // R1
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc)); // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    en |=> pc == $past(next_pc)); // R10
  AST_SEQ_FLOW: assert property (@(posedge clk) disable iff (rst)
    (op < 6'd2 || op > 6'd5) |-> next_pc == ref4); // R3
  AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd4 && !regs_equal) |-> next_pc == ref4); // R6
  AST_JUMP_SPLICE: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2 || op == 6'd3) |->
      (next_pc[31:28] == ref4[31:28] && next_pc[27:2] == instr[25:0] && next_pc[1:0] == 2'b00)); // R7
  AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> (op == 6'd3 && en)); // R8
  AST_LINK_ADDR: assert property (@(posedge clk) disable iff (rst)
    link_addr == ref4); // R8
endmodule

bind npc_unit npc_unit_chk u_chk (.*);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst, en, regs_equal;
  logic [31:0] instr;
  logic [31:0] pc, next_pc, link_addr;
  logic        link_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  npc_unit u0 (
    .clk(clk), .rst(rst), .en(en), .instr(instr), .regs_equal(regs_equal),
    .pc(pc), .next_pc(next_pc), .link_addr(link_addr), .link_valid(link_valid)
  );

  typedef struct packed {
    logic [31:0] ins;
    logic        eq;
    logic [31:0] nxt;
    logic        lnk;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h012A4020,                      1'b0, 32'h0000_0004, 1'b0, 8'd3}, // R3 register-type add
    '{{6'd4, 5'd9, 5'd0, 16'h0003},      1'b1, 32'h0000_0014, 1'b0, 8'd4}, // R4 forward beq
    '{{6'd4, 5'd9, 5'd0, 16'h0003},      1'b0, 32'h0000_0018, 1'b0, 8'd6}, // R6 beq not taken
    '{{6'd5, 5'd9, 5'd0, 16'hFFFE},      1'b0, 32'h0000_0014, 1'b0, 8'd5}, // R5 backward bne
    '{{6'd5, 5'd9, 5'd0, 16'h0005},      1'b1, 32'h0000_0018, 1'b0, 8'd6}, // R6 bne not taken
    '{{6'd2, 26'h0000040},               1'b0, 32'h0000_0100, 1'b0, 8'd7}, // R7 jump
    '{{6'd3, 26'h0000080},               1'b0, 32'h0000_0200, 1'b1, 8'd8}, // R8 jump-and-link
    '{{6'd35, 5'd2, 5'd8, 16'h0004},     1'b1, 32'h0000_0204, 1'b0, 8'd3}, // R3 load, flag ignored
    '{{6'd4, 5'd1, 5'd1, 16'h8000},      1'b1, 32'hFFFE_0208, 1'b0, 8'd4}, // R4 most negative offset
    '{{6'd8, 5'd22, 5'd21, 16'hFFCE},    1'b1, 32'hFFFE_020C, 1'b0, 8'd3}, // R3 add-immediate
    '{{6'd4, 5'd1, 5'd1, 16'h7FFF},      1'b1, 32'h0000_020C, 1'b0, 8'd9}, // R9 wrap upward
    '{{6'd2, 26'h3FFFFFF},               1'b0, 32'h0FFF_FFFC, 1'b0, 8'd7}, // R7 top of region 0
    '{{6'd3, 26'h0000000},               1'b0, 32'h1000_0000, 1'b1, 8'd7}, // R7 region from PC+4
    '{{6'd5, 5'd3, 5'd4, 16'hFFFF},      1'b0, 32'h1000_0000, 1'b0, 8'd5}  // R5 branch to self
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pexp;
    rst = 1'b1; en = 1'b1; regs_equal = 1'b0; instr = 32'h0;
    @(negedge clk);
    step();
    chk("R1 reset value", pc, 32'h0);
    chk("R8 link strobe low in reset", {31'h0, link_valid}, 32'h0);
    rst = 1'b0;
    pexp = 32'h0;

    for (int i = 0; i < NV; i++) begin
      instr = VECS[i].ins;
      regs_equal = VECS[i].eq;
      #1;
      chk($sformatf("R%0d vector %0d pc", VECS[i].req, i), pc, pexp);
      chk($sformatf("R%0d vector %0d next_pc", VECS[i].req, i), next_pc, VECS[i].nxt);
      chk($sformatf("R8 vector %0d link_valid", i), {31'h0, link_valid}, {31'h0, VECS[i].lnk});
      chk($sformatf("R8 vector %0d link_addr", i), link_addr, pexp + 32'd4);
      step();
      chk($sformatf("R10 vector %0d pc after edge", i), pc, VECS[i].nxt);
      pexp = VECS[i].nxt;
    end

    // R1: reset wins over a pending jump
    rst = 1'b1; instr = {6'd2, 26'h0000055};
    step();
    chk("R1 reset during jump", pc, 32'h0);
    rst = 1'b0;

    // R2: hold with jump-and-link present
    en = 1'b0; instr = {6'd3, 26'h0000010};
    #1;
    chk("R8 strobe low while held", {31'h0, link_valid}, 32'h0);
    chk("R7 target computed while held", next_pc, 32'h0000_0040);
    step();
    step();
    chk("R2 pc held", pc, 32'h0);
    en = 1'b1;

    // R9: backward wrap below zero and sequential wrap to zero
    instr = {6'd4, 5'd0, 5'd0, 16'hFFFE}; regs_equal = 1'b1;
    #1;
    chk("R9 backward wrap next_pc", next_pc, 32'hFFFF_FFFC);
    step();
    chk("R9 pc at top", pc, 32'hFFFF_FFFC);
    instr = 32'h012A4020;
    #1;
    chk("R9 sequential wrap next_pc", next_pc, 32'h0);
    chk("R9 link addr wraps", link_addr, 32'h0);
    step();
    chk("R9 pc wrapped", pc, 32'h0);

    // R1: reset with enable low
    step();
    chk("R10 advance before reset", pc, 32'h4);
    en = 1'b0; rst = 1'b1;
    step();
    chk("R1 reset with en low", pc, 32'h0);
    rst = 1'b0; en = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule